// File: doc/BRIEF.md
# Universal Shift/Storage Register with Shared Parallel Bus

This block is a register of `WIDTH` bits (eight by default) that can hold its contents, shift toward the high bit, shift toward the low bit, or take a parallel word. A two-bit select chooses the operation. Every change except reset takes place on the rising clock edge.

The parallel data pins are shared: the same bus carries the word loaded in and the register contents driven out. The shared bus is modelled as three ports. `bus_in` is the resolved value on the wire. `bus_out` carries the register contents. `bus_oe` is high when the block should drive the wire. Two active-low enables gate the driver. The load select also releases the bus, so that outside logic can place a word on it.

Each shift direction has its own serial input. The lowest and the highest bit are always available on dedicated serial outputs. Two or more registers can therefore be chained into one longer register: one register's high serial output feeds the next register's up-shift input, and that register's low serial output feeds the first register's down-shift input. An active-low reset clears the register at once, without waiting for a clock edge.

Top module: `usr_shift_reg`

## Requirements
- R1: With select `2'b00` the contents are unchanged by a rising clock edge.
- R2: With select `2'b01` (shift up) a rising edge moves bit n into bit n+1 for every n, and `ser_in_up` enters bit 0.
- R3: With select `2'b10` (shift down) a rising edge moves bit n into bit n-1 for every n, and `ser_in_dn` enters bit WIDTH-1.
- R4: With select `2'b11` (load) a rising edge copies `bus_in` into the register.
- R5: `rst_n` low clears all bits at once, with no clock edge needed. It overrides the select and the clock for as long as it stays low.
- R6: `bus_oe` is 1 only when `oe_a_n` and `oe_b_n` are both 0 and the select is not `2'b11`. In every other case it is 0.
- R7: Hold, shift, load and reset behave the same whether the bus driver is enabled or not. `bus_out` always shows the register contents.
- R8: `ser_out_lo` always equals bit 0 and `ser_out_hi` always equals bit WIDTH-1, whatever the enables are.
- R9: Two instances chained through their serial ports, with the select, enables and clock shared, behave as a single register of 2*WIDTH bits in all four modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes except reset happen on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_in_dn | input | 1 | Serial bit entering bit WIDTH-1 on a shift down |
| oe_a_n | input | 1 | Bus driver enable, active low |
| oe_b_n | input | 1 | Second bus driver enable, active low |
| bus_in | input | WIDTH | Resolved value of the shared parallel bus |
| bus_out | output | WIDTH | Register contents presented to the bus |
| bus_oe | output | 1 | High when the block drives the shared bus |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Bit WIDTH-1 of the register |

## Verification
The register contents appear directly on `bus_out`, so a wrong bit shows at the ports in the cycle after the edge that produced it. It also stays visible, because hold keeps it and the shifts carry it out through a serial output. A wrong mode decode or a wrong neighbour connection corrupts the word one cycle after the faulty shift. The bench sees this at once by comparing against a model. A wrong enable decode shows on `bus_oe` in the same cycle, with no clock edge needed.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  drive;
    } ctrl_t;

    function automatic mode_e sel_to_mode(input logic [1:0] sel);
        mode_e m;
        case (sel)
            2'b01:   m = MODE_UP;
            2'b10:   m = MODE_DOWN;
            2'b11:   m = MODE_LOAD;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

    function automatic logic cell_next(input mode_e mode, input logic own,
                                       input logic below, input logic above,
                                       input logic ext);
        logic n;
        case (mode)
            MODE_UP:   n = below;
            MODE_DOWN: n = above;
            MODE_LOAD: n = ext;
            default:   n = own;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/usr_decode.sv
module usr_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output ctrl_t      ctrl
);

    logic load_sel;
    logic enables_on;

    always_comb begin
        load_sel   = sel[0] & sel[1];
        enables_on = ~oe_a_n & ~oe_b_n;
        ctrl.mode  = sel_to_mode(sel);
        ctrl.drive = enables_on & ~load_sel;
    end

endmodule

// File: rtl/usr_core.sv
module usr_core
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    input  logic [WIDTH-1:0] load_d,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] d_w;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic below;
        logic above;
        if (i == 0) begin : g_lo
            assign below = ser_in_up;
        end else begin : g_lo_mid
            assign below = q_r[i-1];
        end
        if (i == TOP) begin : g_hi
            assign above = ser_in_dn;
        end else begin : g_hi_mid
            assign above = q_r[i+1];
        end
        always_comb d_w[i] = cell_next(mode, q_r[i], below, above, load_d[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_w;
    end

    assign q = q_r;

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> (q_r == $past(q_r)));                      // R1

    AST_UP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP) |=> (q_r[0] == $past(ser_in_up)
                               && q_r[TOP:1] == $past(q_r[TOP-1:0])));     // R2

    AST_DOWN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN) |=> (q_r[TOP] == $past(ser_in_dn)
                                 && q_r[TOP-1:0] == $past(q_r[TOP:1])));   // R3

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (q_r == $past(load_d)));                   // R4

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q_r == '0));                                     // R5

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH-1:0] q;

    usr_decode u_decode (
        .sel    (sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .ctrl   (ctrl)
    );

    usr_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ctrl.mode),
        .ser_in_up (ser_in_up),
        .ser_in_dn (ser_in_dn),
        .load_d    (bus_in),
        .q         (q)
    );

    assign bus_out    = q;
    assign bus_oe     = ctrl.drive;
    assign ser_out_lo = q[0];
    assign ser_out_hi = q[TOP];

    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> !bus_oe);                                       // R6

    AST_DISABLED_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_oe);                                   // R6

    AST_SER_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[TOP]));       // R8

endmodule

// File: tb/usr_shift_reg_tb.sv
`timescale 1ns/1ps
module usr_shift_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       s_up = 1'b0, s_dn = 1'b0, oa = 1'b1, ob = 1'b1;
    logic [7:0] d8 = '0;
    logic [15:0] d16 = '0;
    logic [7:0] q8, lo_q, hi_q;
    logic       oe8, so_lo, so_hi, lo_oe, hi_oe, lo_slo, lo_shi, hi_slo, hi_shi;
    logic [7:0] m8 = '0;
    logic [15:0] m16 = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_in_up(s_up), .ser_in_dn(s_dn),
        .oe_a_n(oa), .oe_b_n(ob), .bus_in(d8), .bus_out(q8), .bus_oe(oe8),
        .ser_out_lo(so_lo), .ser_out_hi(so_hi));

    usr_shift_reg #(.WIDTH(8)) u_lo (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_in_up(s_up), .ser_in_dn(hi_slo),
        .oe_a_n(oa), .oe_b_n(ob), .bus_in(d16[7:0]), .bus_out(lo_q), .bus_oe(lo_oe),
        .ser_out_lo(lo_slo), .ser_out_hi(lo_shi));

    usr_shift_reg #(.WIDTH(8)) u_hi (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_in_up(lo_shi), .ser_in_dn(s_dn),
        .oe_a_n(oa), .oe_b_n(ob), .bus_in(d16[15:8]), .bus_out(hi_q), .bus_oe(hi_oe),
        .ser_out_lo(hi_slo), .ser_out_hi(hi_shi));

    function automatic logic [7:0] ref8(logic [7:0] q, logic [1:0] s, logic u,
                                        logic dn, logic [7:0] d);
        case (s)
            2'b01:   return {q[6:0], u};
            2'b10:   return {dn, q[7:1]};
            2'b11:   return d;
            default: return q;
        endcase
    endfunction

    function automatic logic [15:0] ref16(logic [15:0] q, logic [1:0] s, logic u,
                                          logic dn, logic [15:0] d);
        case (s)
            2'b01:   return {q[14:0], u};
            2'b10:   return {dn, q[15:1]};
            2'b11:   return d;
            default: return q;
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] s);
        case (s)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at a falling edge, check the enable, then check contents after the next rising edge.
    task automatic cycle(logic [1:0] s, logic u, logic dn, logic [7:0] d,
                         logic [15:0] dd, logic a, logic b);
        logic exp_oe;
        sel = s; s_up = u; s_dn = dn; d8 = d; d16 = dd; oa = a; ob = b;
        #1;
        exp_oe = !a && !b && (s != 2'b11);
        chk("R6", {15'd0, oe8}, {15'd0, exp_oe});
        @(negedge clk);
        m8  = ref8(m8, s, u, dn, d);
        m16 = ref16(m16, s, u, dn, dd);
        chk(exp_oe ? mode_tag(s) : "R7", {8'd0, q8}, {8'd0, m8});
        chk("R8", {14'd0, so_hi, so_lo}, {14'd0, m8[7], m8[0]});
        chk("R9", {hi_q, lo_q}, m16);
    endtask

    initial begin
        void'($urandom(32'h5eed_0299));
        repeat (3) @(negedge clk);
        chk("R5", {8'd0, q8}, 16'd0);
        chk("R5", {hi_q, lo_q}, 16'd0);
        rst_n = 1'b1;

        // directed corner cases
        cycle(2'b11, 0, 0, 8'hA5, 16'hC33C, 0, 0);   // R4 load, bus released
        cycle(2'b00, 1, 1, 8'hFF, 16'hFFFF, 0, 0);   // R1 hold ignores inputs
        cycle(2'b01, 1, 0, 8'h00, 16'h0000, 0, 0);   // R2
        cycle(2'b10, 0, 1, 8'h00, 16'h0000, 0, 0);   // R3
        cycle(2'b01, 0, 0, 8'h00, 16'h0000, 1, 0);   // R7 disabled, still shifts
        cycle(2'b10, 1, 1, 8'h00, 16'h0000, 0, 1);   // R7
        cycle(2'b11, 0, 0, 8'h80, 16'h8001, 1, 1);   // R4 load with enables off
        repeat (9) cycle(2'b01, 1'b0, 1'b0, 8'h00, 16'h0, 0, 0);  // R9 carry across
        repeat (9) cycle(2'b10, 1'b1, 1'b0, 8'h00, 16'h0, 0, 0);  // R9 carry back

        // reset in the middle of operation: clear without a clock edge
        cycle(2'b11, 0, 0, 8'h7E, 16'hBEEF, 0, 0);
        rst_n = 1'b0; sel = 2'b11; d8 = 8'hFF; d16 = 16'hFFFF;
        #2;
        chk("R5", {8'd0, q8}, 16'd0);
        chk("R5", {hi_q, lo_q}, 16'd0);
        @(negedge clk);
        chk("R5", {8'd0, q8}, 16'd0);
        chk("R5", {hi_q, lo_q}, 16'd0);
        m8 = '0; m16 = '0;
        rst_n = 1'b1;

        // constrained random
        for (int k = 0; k < 600; k++) begin
            logic [1:0] rs;
            logic ra, rb;
            rs = 2'($urandom);
            ra = ($urandom % 4) == 0;
            rb = ($urandom % 4) == 0;
            cycle(rs, 1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), ra, rb);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule